// File: doc/BRIEF.md
# DMA channel event and interrupt controller

This block follows the progress of a group of DMA channels and turns their events into interrupt requests. Each channel has a programmed transfer length, a per-beat completion strobe from the bus master, a bus error indication and a set of peripheral request inputs. From these it keeps three status flags per channel: half done, fully done and bus error. Each flag has its own write-one-to-clear input and its own interrupt enable.

Each channel is a four-state machine:
- `CH_IDLE` goes to `CH_RUN` when the channel is enabled with a nonzero length, or to `CH_DONE` with a zero length.
- `CH_RUN` goes to `CH_DONE` on the beat that empties the count, to `CH_HALT` on a bus error, and to `CH_IDLE` when the channel is disabled.
- `CH_DONE` and `CH_HALT` leave only by disable, to `CH_IDLE`.

Peripheral requests are OR-merged per channel and passed on only while the channel runs. The per-channel interrupt lines are mapped onto vectors. The lowest channels each get a vector of their own, and the rest share a vector in fixed pairs.

Top module: `dma_evt_ctrl`

## Requirements
- R1: While the channel is enabled in `CH_IDLE`, the remaining count loads the programmed length on the next edge. In `CH_RUN`, each beat strobe without an error decrements the count by one. A zero length goes to `CH_DONE` with no flag. Outside `CH_RUN` the count holds its value.
- R2: The half flag sets on the beat where the remaining count becomes the programmed length shifted right by one (rounded down). For a length of 1 this is the same beat as completion.
- R3: The full flag sets on the beat where the remaining count reaches zero. Later beats are ignored until the channel is disabled and enabled again.
- R4: A bus error while running sets the error flag, and the beat in that cycle is not counted. The channel then ignores beats, freezes its count and blocks requests until it is disabled and enabled again.
- R5: A 1 on a clear input clears the matching flag at the next edge. If that flag's event occurs in the same cycle, the flag is set.
- R6: Flags hold their value whatever the enable bits are. They also hold when the channel is disabled, until they are cleared.
- R7: `ch_irq_o[i]` = (half & ie_half) | (full & ie_full) | (err & ie_err) of channel i. Bit i of every per-channel vector belongs to channel i.
- R8: Vector v < PAIR_BASE carries channel v alone. Vector PAIR_BASE+k carries channels PAIR_BASE+2k and PAIR_BASE+2k+1 ORed together; an unpaired last channel is carried alone. With the defaults, channels 3|4 share vector 3 and channels 5|6 share vector 4.
- R9: `dma_req_o[i]` is the OR of channel i's peripheral request inputs (bits i*NUM_REQ upward), gated by the channel being in `CH_RUN`.
- R10: After reset all channels are in `CH_IDLE`, and all counts, flags, requests and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en_i | input | NUM_CH | Channel enable |
| xfer_len_i | input | NUM_CH*CNT_W | Programmed length per channel |
| beat_i | input | NUM_CH | One beat completed |
| bus_err_i | input | NUM_CH | Bus returned an error on a read or write |
| periph_req_i | input | NUM_CH*NUM_REQ | Peripheral request inputs |
| ie_half_i | input | NUM_CH | Half flag interrupt enable |
| ie_full_i | input | NUM_CH | Full flag interrupt enable |
| ie_err_i | input | NUM_CH | Error flag interrupt enable |
| clr_half_i | input | NUM_CH | Clear half flag |
| clr_full_i | input | NUM_CH | Clear full flag |
| clr_err_i | input | NUM_CH | Clear error flag |
| flag_half_o | output | NUM_CH | Half flags |
| flag_full_o | output | NUM_CH | Full flags |
| flag_err_o | output | NUM_CH | Error flags |
| rem_cnt_o | output | NUM_CH*CNT_W | Remaining count |
| dma_req_o | output | NUM_CH | Merged request, running channels only |
| ch_irq_o | output | NUM_CH | Per-channel interrupt |
| irq_vec_o | output | NUM_VEC | Interrupt vectors |

## Verification
The hardest situations to reach from the ports are a clear that lands in the same cycle as the event it would clear, and a bus error on the very beat that would finish a transfer. Random stimulus rarely lines these up. Directed sequences with short lengths drive the beat, the error and the clear strobes on exactly those cycles, then keep beating to show that the halted or finished channel stays put. A long seeded random run then recycles channels with lengths from 0 to 12 against a bench model.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2,
        CH_HALT = 2'd3
    } ch_state_t;

    typedef struct packed {
        logic half;
        logic full;
        logic err;
    } evt_t;

endpackage

// File: rtl/dma_evt_chan.sv
module dma_evt_chan
    import dma_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             beat_i,
    input  logic             err_i,
    input  logic             req_any_i,
    output evt_t             evt_o,
    output logic [CNT_W-1:0] rem_o,
    output logic             req_o
);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic [CNT_W-1:0] mark_q, mark_d;
    logic [CNT_W-1:0] rem_dec;
    logic             run_ok;

    assign rem_dec = rem_q - CNT_W'(1);
    assign run_ok  = (state_q == CH_RUN) && en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            rem_q   <= '0;
            mark_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            mark_q  <= mark_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        mark_d  = mark_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en_i) begin
                    rem_d   = len_i;
                    mark_d  = len_i >> 1;
                    state_d = (len_i == '0) ? CH_DONE : CH_RUN;
                end
            end
            CH_RUN: begin
                if (!en_i) begin
                    state_d = CH_IDLE;
                end else if (err_i) begin
                    state_d = CH_HALT;
                end else if (beat_i) begin
                    rem_d = rem_dec;
                    if (rem_dec == '0) begin
                        state_d = CH_DONE;
                    end
                end
            end
            CH_DONE: begin
                if (!en_i) state_d = CH_IDLE;
            end
            CH_HALT: begin
                if (!en_i) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        evt_o.err  = run_ok && err_i;
        evt_o.half = run_ok && !err_i && beat_i && (rem_dec == mark_q);
        evt_o.full = run_ok && !err_i && beat_i && (rem_dec == '0);
        rem_o      = rem_q;
        req_o      = (state_q == CH_RUN) && req_any_i;
    end

endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags
    import dma_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t set_i,
    input  evt_t clr_i,
    input  evt_t ie_i,
    output evt_t flag_o,
    output logic irq_o
);

    evt_t flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= set_i | (flag_q & ~clr_i);
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & ie_i);

endmodule

// File: rtl/dma_evt_vecmap.sv
module dma_evt_vecmap #(
    parameter int NUM_CH    = 7,
    parameter int PAIR_BASE = 3,
    parameter int NUM_VEC   = PAIR_BASE + (NUM_CH - PAIR_BASE + 1) / 2
) (
    input  logic [NUM_CH-1:0]  ch_irq_i,
    output logic [NUM_VEC-1:0] vec_o
);

    localparam int NUM_PAIR = NUM_VEC - PAIR_BASE;

    for (genvar v = 0; v < PAIR_BASE; v++) begin : g_solo
        assign vec_o[v] = ch_irq_i[v];
    end

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        localparam int A = PAIR_BASE + 2 * k;
        if (A + 1 < NUM_CH) begin : g_two
            assign vec_o[PAIR_BASE+k] = ch_irq_i[A] | ch_irq_i[A+1];
        end else begin : g_one
            assign vec_o[PAIR_BASE+k] = ch_irq_i[A];
        end
    end

endmodule

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH    = 7,
    parameter int NUM_REQ   = 4,
    parameter int CNT_W     = 16,
    parameter int PAIR_BASE = 3,
    localparam int NUM_VEC  = PAIR_BASE + (NUM_CH - PAIR_BASE + 1) / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         ch_en_i,
    input  logic [NUM_CH*CNT_W-1:0]   xfer_len_i,
    input  logic [NUM_CH-1:0]         beat_i,
    input  logic [NUM_CH-1:0]         bus_err_i,
    input  logic [NUM_CH*NUM_REQ-1:0] periph_req_i,
    input  logic [NUM_CH-1:0]         ie_half_i,
    input  logic [NUM_CH-1:0]         ie_full_i,
    input  logic [NUM_CH-1:0]         ie_err_i,
    input  logic [NUM_CH-1:0]         clr_half_i,
    input  logic [NUM_CH-1:0]         clr_full_i,
    input  logic [NUM_CH-1:0]         clr_err_i,
    output logic [NUM_CH-1:0]         flag_half_o,
    output logic [NUM_CH-1:0]         flag_full_o,
    output logic [NUM_CH-1:0]         flag_err_o,
    output logic [NUM_CH*CNT_W-1:0]   rem_cnt_o,
    output logic [NUM_CH-1:0]         dma_req_o,
    output logic [NUM_CH-1:0]         ch_irq_o,
    output logic [NUM_VEC-1:0]        irq_vec_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evt_t evt;
        evt_t flg;
        evt_t clr;
        evt_t ie;
        logic req_any;

        assign req_any = |periph_req_i[i*NUM_REQ +: NUM_REQ];
        assign clr     = '{half: clr_half_i[i], full: clr_full_i[i], err: clr_err_i[i]};
        assign ie      = '{half: ie_half_i[i],  full: ie_full_i[i],  err: ie_err_i[i]};

        dma_evt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ch_en_i[i]),
            .len_i     (xfer_len_i[i*CNT_W +: CNT_W]),
            .beat_i    (beat_i[i]),
            .err_i     (bus_err_i[i]),
            .req_any_i (req_any),
            .evt_o     (evt),
            .rem_o     (rem_cnt_o[i*CNT_W +: CNT_W]),
            .req_o     (dma_req_o[i])
        );

        dma_evt_flags u_flags (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt),
            .clr_i  (clr),
            .ie_i   (ie),
            .flag_o (flg),
            .irq_o  (ch_irq_o[i])
        );

        assign flag_half_o[i] = flg.half;
        assign flag_full_o[i] = flg.full;
        assign flag_err_o[i]  = flg.err;
    end

    dma_evt_vecmap #(
        .NUM_CH    (NUM_CH),
        .PAIR_BASE (PAIR_BASE),
        .NUM_VEC   (NUM_VEC)
    ) u_vecmap (
        .ch_irq_i (ch_irq_o),
        .vec_o    (irq_vec_o)
    );

endmodule

// File: rtl/dma_evt_chk.sv
module dma_evt_chk #(
    parameter int NUM_CH  = 7,
    parameter int NUM_REQ = 4,
    parameter int CNT_W   = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         ch_en_i,
    input logic [NUM_CH-1:0]         bus_err_i,
    input logic [NUM_CH*NUM_REQ-1:0] periph_req_i,
    input logic [NUM_CH-1:0]         clr_half_i,
    input logic [NUM_CH-1:0]         clr_full_i,
    input logic [NUM_CH-1:0]         clr_err_i,
    input logic [NUM_CH-1:0]         flag_half_o,
    input logic [NUM_CH-1:0]         flag_full_o,
    input logic [NUM_CH-1:0]         flag_err_o,
    input logic [NUM_CH*CNT_W-1:0]   rem_cnt_o,
    input logic [NUM_CH-1:0]         dma_req_o,
    input logic [NUM_CH-1:0]         ch_irq_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        AST_REM_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en_i[i] |=> $stable(rem_cnt_o[i*CNT_W +: CNT_W])); // R1
        AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_full_o[i]) |-> (rem_cnt_o[i*CNT_W +: CNT_W] == '0)); // R3
        AST_ERR_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_err_o[i]) |-> $past(bus_err_i[i])); // R4
        AST_FULL_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_full_o[i]) |-> $past(clr_full_i[i])); // R5
        AST_HALF_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_half_o[i]) |-> $past(clr_half_i[i])); // R5
        AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_err_o[i] && !clr_err_i[i]) |=> flag_err_o[i]); // R6
        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ch_irq_o[i] |-> (flag_half_o[i] || flag_full_o[i] || flag_err_o[i])); // R7
        AST_REQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req_o[i] |-> (|periph_req_i[i*NUM_REQ +: NUM_REQ])); // R9
    end

endmodule

bind dma_evt_ctrl dma_evt_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_REQ (NUM_REQ),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_en_i      (ch_en_i),
    .bus_err_i    (bus_err_i),
    .periph_req_i (periph_req_i),
    .clr_half_i   (clr_half_i),
    .clr_full_i   (clr_full_i),
    .clr_err_i    (clr_err_i),
    .flag_half_o  (flag_half_o),
    .flag_full_o  (flag_full_o),
    .flag_err_o   (flag_err_o),
    .rem_cnt_o    (rem_cnt_o),
    .dma_req_o    (dma_req_o),
    .ch_irq_o     (ch_irq_o)
);

// File: tb/tb_dma_evt_ctrl.sv
module tb_dma_evt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 7;
    localparam int NR = 4;
    localparam int CW = 16;
    localparam int PB = 3;
    localparam int NV = PB + (NC - PB + 1) / 2;
    localparam int RAND_CYCLES = 6000;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    ch_en = '0, beat = '0, berr = '0;
    logic [NC*CW-1:0] len = '0;
    logic [NC*NR-1:0] preq = '0;
    logic [NC-1:0]    ieh = '0, ief = '0, iee = '0, clh = '0, clf = '0, cle = '0;
    logic [NC-1:0]    fh, ff, fe, dreq, cirq;
    logic [NC*CW-1:0] rem;
    logic [NV-1:0]    vec;

    int checks = 0;
    int fails = 0;

    // model: 0 idle, 1 run, 2 done, 3 halt
    int m_st[NC];
    int m_rem[NC];
    int m_mark[NC];
    bit m_fh[NC];
    bit m_ff[NC];
    bit m_fe[NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_evt_ctrl #(.NUM_CH(NC), .NUM_REQ(NR), .CNT_W(CW), .PAIR_BASE(PB)) dut (
        .clk(clk), .rst_n(rst_n), .ch_en_i(ch_en), .xfer_len_i(len),
        .beat_i(beat), .bus_err_i(berr), .periph_req_i(preq),
        .ie_half_i(ieh), .ie_full_i(ief), .ie_err_i(iee),
        .clr_half_i(clh), .clr_full_i(clf), .clr_err_i(cle),
        .flag_half_o(fh), .flag_full_o(ff), .flag_err_o(fe),
        .rem_cnt_o(rem), .dma_req_o(dreq), .ch_irq_o(cirq), .irq_vec_o(vec)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq(int i);
        return (m_fh[i] & ieh[i]) | (m_ff[i] & ief[i]) | (m_fe[i] & iee[i]);
    endfunction

    task automatic check_all();
        logic [NC-1:0] eh, ef, ee, er, ei;
        logic [NV-1:0] ev;
        for (int i = 0; i < NC; i++) begin
            eh[i] = m_fh[i];
            ef[i] = m_ff[i];
            ee[i] = m_fe[i];
            er[i] = (m_st[i] == 1) && (|preq[i*NR +: NR]);
            ei[i] = exp_irq(i);
            check($sformatf("R1 rem ch%0d", i), 32'(rem[i*CW +: CW]), 32'(m_rem[i]));
        end
        for (int v = 0; v < NV; v++) begin
            if (v < PB) ev[v] = ei[v];
            else if (PB + 2*(v-PB) + 1 < NC) ev[v] = ei[PB+2*(v-PB)] | ei[PB+2*(v-PB)+1];
            else ev[v] = ei[PB+2*(v-PB)];
        end
        check("R2 R5 R6 half flags", 32'(fh), 32'(eh));
        check("R3 R5 R6 full flags", 32'(ff), 32'(ef));
        check("R4 R5 R6 err flags", 32'(fe), 32'(ee));
        check("R9 R4 dma_req", 32'(dreq), 32'(er));
        check("R7 ch_irq", 32'(cirq), 32'(ei));
        check("R8 irq_vec", 32'(vec), 32'(ev));
    endtask

    task automatic model_step();
        for (int i = 0; i < NC; i++) begin
            bit sh = 0, sf = 0, se = 0;
            int nr;
            if (!ch_en[i]) begin
                m_st[i] = 0;
            end else begin
                case (m_st[i])
                    0: begin
                        m_rem[i]  = int'(len[i*CW +: CW]);
                        m_mark[i] = m_rem[i] / 2;
                        m_st[i]   = (m_rem[i] == 0) ? 2 : 1;
                    end
                    1: begin
                        if (berr[i]) begin
                            se = 1; m_st[i] = 3;
                        end else if (beat[i]) begin
                            nr = m_rem[i] - 1;
                            sh = (nr == m_mark[i]);
                            sf = (nr == 0);
                            m_rem[i] = nr;
                            if (nr == 0) m_st[i] = 2;
                        end
                    end
                    default: ;
                endcase
            end
            m_fh[i] = sh | (m_fh[i] & !clh[i]);
            m_ff[i] = sf | (m_ff[i] & !clf[i]);
            m_fe[i] = se | (m_fe[i] & !cle[i]);
        end
    endtask

    // inputs already driven after a negedge: check, predict, wait for next negedge
    task automatic step();
        #1;
        check_all();
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        beat = '0; berr = '0; clh = '0; clf = '0; cle = '0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < NC; i++) begin
            m_st[i] = 0; m_rem[i] = 0; m_mark[i] = 0;
            m_fh[i] = 0; m_ff[i] = 0; m_fe[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check_all();
        check("R10 flags zero", 32'(fh | ff | fe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        ieh = '1; ief = '1; iee = '1;

        // directed: ch0 len 2, complete with simultaneous clears (R5 set wins, R2, R3)
        len[0*CW +: CW] = 16'd2; ch_en[0] = 1'b1; preq[0*NR +: NR] = 4'b0100;
        step();
        beat[0] = 1'b1; step();
        clh[0] = 1'b1; clf[0] = 1'b1; step();
        clh[0] = 1'b0; clf[0] = 1'b0; step();
        step();
        check("R3 full held after extra beats", 32'(ff[0]), 32'h1);
        idle_inputs();

        // directed: ch1 len 3, error on a beat (R4)
        len[1*CW +: CW] = 16'd3; ch_en[1] = 1'b1; preq[1*NR +: NR] = 4'b0001;
        step();
        beat[1] = 1'b1; step();
        berr[1] = 1'b1; step();
        berr[1] = 1'b0; step();
        step();
        check("R4 count frozen after halt", 32'(rem[1*CW +: CW]), 32'd2);
        // R6: enable bits off, flags stay
        ieh = '0; ief = '0; iee = '0; beat = '0;
        step();
        check("R6 err flag polled", 32'(fe[1]), 32'h1);
        // restart ch1 (R4 recovery), len 1 -> half and full on same beat (R2)
        ch_en[1] = 1'b0; step();
        len[1*CW +: CW] = 16'd1; ch_en[1] = 1'b1; cle[1] = 1'b1; step();
        cle[1] = 1'b0; beat[1] = 1'b1; step();
        beat[1] = 1'b0; step();
        check("R2 half at len 1", 32'(fh[1]), 32'h1);
        // ch2 len 0 goes done without flags (R1)
        len[2*CW +: CW] = 16'd0; ch_en[2] = 1'b1; beat[2] = 1'b1; step();
        step();
        check("R1 zero length no flag", 32'(ff[2] | fh[2]), 32'h0);
        // error on the completing beat of ch3 (R4 over R3)
        len[3*CW +: CW] = 16'd1; ch_en[3] = 1'b1; iee = '1; step();
        beat[3] = 1'b1; berr[3] = 1'b1; step();
        berr[3] = 1'b0; step();
        check("R4 error beats completion", 32'(ff[3]), 32'h0);
        check("R8 pair vector from ch3", 32'(vec[3]), 32'h1);
        idle_inputs();

        // random phase
        for (int c = 0; c < RAND_CYCLES; c++) begin
            for (int i = 0; i < NC; i++) begin
                if (ch_en[i]) begin
                    if ($urandom_range(((m_st[i] >= 2) ? 6 : 40) - 1) == 0) ch_en[i] = 1'b0;
                end else if ($urandom_range(2) == 0) begin
                    ch_en[i] = 1'b1;
                    len[i*CW +: CW] = 16'($urandom_range(12));
                end
                beat[i] = ($urandom_range(1) == 0);
                berr[i] = ($urandom_range(59) == 0);
                clh[i]  = ($urandom_range(9) == 0);
                clf[i]  = ($urandom_range(9) == 0);
                cle[i]  = ($urandom_range(9) == 0);
                if ($urandom_range(19) == 0) begin
                    ieh[i] = 1'($urandom); ief[i] = 1'($urandom); iee[i] = 1'($urandom);
                end
                preq[i*NR +: NR] = ($urandom_range(3) == 0) ? 4'b0 : NR'($urandom);
            end
            step();
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule